// File: doc/BRIEF.md
# Serial FPGA configuration sequencer

This block loads a configuration bitstream into a downstream FPGA over a slave-serial link. A start pulse launches the whole handshake. The block drives the active-low program pin low until the device pulls its active-low init line low. It then releases program and waits for init to return high. Next it takes bitstream bytes from a byte stream with valid/ready handshaking and shifts them to the device on a clock/data pin pair. Finally it waits for the device's done line.

The leading bytes of the stream are a header that the block throws away. Shifting starts with the first byte of the first run of four consecutive 0xFF bytes, and every byte from there to the one flagged as last goes out most significant bit first. Each of the three waits has its own timeout, counted in ticks of a prescaler that is normally set to one millisecond. The block reports either success or a 2-bit error code, and holds that result until the next start.

Top module: `fpga_serial_loader`

## Requirements
- R1: After reset, and before any start, `prog_n`, `cfg_clk` and `cfg_dout` are high, while `busy`, `done_ok`, `err`, `err_code` and `in_ready` are all zero.
- R2: In the idle state, a `start` pulse drives `prog_n` low and `busy` high in the cycle after it is sampled. A `start` that arrives while `busy` is high has no effect.
- R3: `prog_n` returns high only after `init_n` has been seen low. `in_ready` does not rise until `init_n` has returned high.
- R4: Bytes are dropped until four consecutive 0xFF bytes arrive, and any other byte resets the run. The shifted stream starts with the first of those four 0xFF bytes and includes every later byte up to and including the one marked by `in_last`.
- R5: Each byte is shifted MSB first, 8 bits per byte. For each bit, `cfg_clk` goes low for CLK_DIV cycles with `cfg_dout` already holding the bit, then high for CLK_DIV cycles. `cfg_dout` changes only on the cycle in which `cfg_clk` falls.
- R6: `in_ready` is high only while the block waits for a byte. It is low whenever a byte is being shifted.
- R7: After the last bit, the block waits for `done_in` high. It then sets `done_ok`=1, `busy`=0, `err`=0 and `err_code`=0.
- R8: If `init_n` is not low within INIT_LOW_TICKS prescaler ticks after `prog_n` goes low, the block sets `err`=1 and `err_code`=1.
- R9: If `init_n` is not high within INIT_HIGH_TICKS ticks after `prog_n` is released, the block sets `err`=1 and `err_code`=2.
- R10: If `done_in` is not high within DONE_TICKS ticks after the last bit, the block sets `err`=1 and `err_code`=3. The same code is reported at once if the byte marked `in_last` arrives before the four-byte 0xFF run is complete.
- R11: On any error, `busy` drops, `prog_n`, `cfg_clk` and `cfg_dout` return high, and `err`/`err_code` hold until the next `start`, which clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a configuration run |
| in_valid | input | 1 | Bitstream byte on `in_data` is valid |
| in_data | input | 8 | Bitstream byte |
| in_last | input | 1 | Marks the final byte of the bitstream |
| in_ready | output | 1 | Block accepts the byte this cycle |
| prog_n | output | 1 | Active-low program pin to the device |
| cfg_clk | output | 1 | Configuration clock to the device |
| cfg_dout | output | 1 | Serial configuration data to the device |
| init_n | input | 1 | Active-low init line from the device |
| done_in | input | 1 | Done line from the device |
| busy | output | 1 | A run is in progress |
| done_ok | output | 1 | Last run finished successfully |
| err | output | 1 | Last run failed |
| err_code | output | 2 | 0 none, 1 init-low timeout, 2 init-high timeout, 3 done timeout or no preamble |

## Verification
The loader is fed several bitstreams. In some the preamble arrives immediately. In some the header holds runs of up to three 0xFF bytes broken by other bytes. In one, header 0xFF bytes run into the preamble so that the run completes early. In one, the stream holds nothing past the preamble. The captured serial bits are compared against a scan for the first four-byte 0xFF run, which separates a correct run reset and correct start position from off-by-one or lost bytes. A device model can hold init high, hold init low or never raise done, so each timeout is reached on its own and its code and tick-counted delay can be told apart. A header-only stream shows the difference between running out of data and a device that never finishes.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_RELEASE,
        ST_FEED,
        ST_SHIFT,
        ST_WAIT_DONE
    } seq_state_e;

    localparam logic [1:0] CODE_NONE      = 2'd0;
    localparam logic [1:0] CODE_INIT_LOW  = 2'd1;
    localparam logic [1:0] CODE_INIT_HIGH = 2'd2;
    localparam logic [1:0] CODE_DONE      = 2'd3;

endpackage

// File: rtl/cfg_prescaler.sv
module cfg_prescaler #(
    parameter int TICK_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == CNT_LAST);

    always_comb begin
        cnt_d = cnt_q + CW'(1);
        if (clr || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/cfg_timeout.sv
module cfg_timeout #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    assign expired = tick && (cnt_q == (limit - W'(1)));

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] byte_in,
    input  logic       park,
    output logic       sclk,
    output logic       sdo,
    output logic       active,
    output logic       fin
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

    typedef struct packed {
        logic [7:0]    sreg;
        logic [2:0]    bit_cnt;
        logic [DW-1:0] div;
        logic          high;
        logic          active;
        logic          sclk;
        logic          sdo;
        logic          fin;
    } shf_t;

    shf_t d, q;

    assign sclk   = q.sclk;
    assign sdo    = q.sdo;
    assign active = q.active;
    assign fin    = q.fin;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        if (park) begin
            d.sclk   = 1'b1;
            d.sdo    = 1'b1;
            d.active = 1'b0;
        end else if (load) begin
            d.sreg    = byte_in;
            d.bit_cnt = '0;
            d.div     = '0;
            d.high    = 1'b0;
            d.active  = 1'b1;
            d.sclk    = 1'b0;
            d.sdo     = byte_in[7];
        end else if (q.active) begin
            if (q.div == DIV_LAST) begin
                d.div = '0;
                if (!q.high) begin
                    d.high = 1'b1;
                    d.sclk = 1'b1;
                end else if (q.bit_cnt == 3'd7) begin
                    d.active = 1'b0;
                    d.fin    = 1'b1;
                end else begin
                    d.bit_cnt = q.bit_cnt + 3'd1;
                    d.sreg    = {q.sreg[6:0], 1'b0};
                    d.sdo     = q.sreg[6];
                    d.sclk    = 1'b0;
                    d.high    = 1'b0;
                end
            end else begin
                d.div = q.div + DW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sclk <= 1'b1;
            q.sdo  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && $past(q.active) && q.sclk && $past(q.sclk)) |-> $stable(q.sdo));

    // R5
    fin_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.fin |-> (q.sclk && !q.active));
endmodule

// File: rtl/fpga_serial_loader.sv
module fpga_serial_loader
    import cfg_seq_pkg::*;
#(
    parameter int          CLK_DIV         = 4,
    parameter int          TICK_CYCLES     = 100000,
    parameter int          INIT_LOW_TICKS  = 3,
    parameter int          INIT_HIGH_TICKS = 50,
    parameter int          DONE_TICKS      = 100,
    parameter int          SYNC_BYTES      = 4,
    parameter logic [7:0]  SYNC_BYTE       = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       prog_n,
    output logic       cfg_clk,
    output logic       cfg_dout,
    input  logic       init_n,
    input  logic       done_in,
    output logic       busy,
    output logic       done_ok,
    output logic       err,
    output logic [1:0] err_code
);
    localparam int SW     = $clog2(SYNC_BYTES);
    localparam int MAX_AB = (INIT_LOW_TICKS > INIT_HIGH_TICKS) ? INIT_LOW_TICKS : INIT_HIGH_TICKS;
    localparam int MAX_T  = (MAX_AB > DONE_TICKS) ? MAX_AB : DONE_TICKS;
    localparam int TW     = $clog2(MAX_T + 1);
    localparam logic [SW-1:0] RUN_LAST = SW'(SYNC_BYTES - 1);

    typedef struct packed {
        seq_state_e    state;
        logic          prog_n;
        logic          busy;
        logic          ok;
        logic          err;
        logic [1:0]    code;
        logic [SW-1:0] run;
        logic          synced;
        logic [SW-1:0] pend;
        logic          last;
    } ctl_t;

    ctl_t d, q;

    logic          tick, expired, tmo_clr;
    logic [TW-1:0] limit_sel;
    logic          sh_load, sh_park, sh_active, sh_fin;
    logic [7:0]    sh_byte;
    logic          hs;

    assign in_ready = (q.state == ST_FEED);
    assign hs       = in_valid && in_ready;
    assign sh_park  = (q.state == ST_IDLE);
    assign tmo_clr  = (d.state != q.state);

    assign prog_n   = q.prog_n;
    assign busy     = q.busy;
    assign done_ok  = q.ok;
    assign err      = q.err;
    assign err_code = q.code;

    always_comb begin
        case (q.state)
            ST_PULSE:   limit_sel = TW'(INIT_LOW_TICKS);
            ST_RELEASE: limit_sel = TW'(INIT_HIGH_TICKS);
            default:    limit_sel = TW'(DONE_TICKS);
        endcase
    end

    cfg_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmo_clr),
        .tick  (tick)
    );

    cfg_timeout #(.W(TW)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmo_clr),
        .tick    (tick),
        .limit   (limit_sel),
        .expired (expired)
    );

    cfg_bit_shifter #(.CLK_DIV(CLK_DIV)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .byte_in (sh_byte),
        .park    (sh_park),
        .sclk    (cfg_clk),
        .sdo     (cfg_dout),
        .active  (sh_active),
        .fin     (sh_fin)
    );

    always_comb begin
        d       = q;
        sh_load = 1'b0;
        sh_byte = SYNC_BYTE;
        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.state  = ST_PULSE;
                    d.prog_n = 1'b0;
                    d.busy   = 1'b1;
                    d.ok     = 1'b0;
                    d.err    = 1'b0;
                    d.code   = CODE_NONE;
                    d.run    = '0;
                    d.synced = 1'b0;
                    d.pend   = '0;
                    d.last   = 1'b0;
                end
            end
            ST_PULSE: begin
                if (!init_n) begin
                    d.state  = ST_RELEASE;
                    d.prog_n = 1'b1;
                end else if (expired) begin
                    d.state  = ST_IDLE;
                    d.prog_n = 1'b1;
                    d.busy   = 1'b0;
                    d.err    = 1'b1;
                    d.code   = CODE_INIT_LOW;
                end
            end
            ST_RELEASE: begin
                if (init_n) begin
                    d.state = ST_FEED;
                end else if (expired) begin
                    d.state = ST_IDLE;
                    d.busy  = 1'b0;
                    d.err   = 1'b1;
                    d.code  = CODE_INIT_HIGH;
                end
            end
            ST_FEED: begin
                if (hs) begin
                    d.last = in_last;
                    if (q.synced) begin
                        sh_load = 1'b1;
                        sh_byte = in_data;
                        d.state = ST_SHIFT;
                    end else if (in_data == SYNC_BYTE && q.run == RUN_LAST) begin
                        d.synced = 1'b1;
                        d.pend   = RUN_LAST;
                        sh_load  = 1'b1;
                        d.state  = ST_SHIFT;
                    end else begin
                        d.run = (in_data == SYNC_BYTE) ? q.run + SW'(1) : '0;
                        if (in_last) begin
                            d.state = ST_IDLE;
                            d.busy  = 1'b0;
                            d.err   = 1'b1;
                            d.code  = CODE_DONE;
                        end
                    end
                end
            end
            ST_SHIFT: begin
                if (sh_fin) begin
                    if (q.pend != '0) begin
                        d.pend  = q.pend - SW'(1);
                        sh_load = 1'b1;
                    end else if (q.last) begin
                        d.state = ST_WAIT_DONE;
                    end else begin
                        d.state = ST_FEED;
                    end
                end
            end
            ST_WAIT_DONE: begin
                if (done_in) begin
                    d.state = ST_IDLE;
                    d.busy  = 1'b0;
                    d.ok    = 1'b1;
                end else if (expired) begin
                    d.state = ST_IDLE;
                    d.busy  = 1'b0;
                    d.err   = 1'b1;
                    d.code  = CODE_DONE;
                end
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.state  <= ST_IDLE;
            q.prog_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // R2
    prog_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.prog_n |-> q.busy);

    // R6
    ready_vs_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && sh_active));

    // R7
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.ok && q.err));

    // R11
    err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> (q.code != CODE_NONE && q.prog_n && !q.busy));

    // R6
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> q.busy);
endmodule

// File: tb/sim_fpga_serial_loader.sv
`timescale 1ns/1ps
module sim_fpga_serial_loader;

    localparam int CLK_DIV = 2;
    localparam int TICK    = 20;
    localparam int T_LOW   = 3;
    localparam int T_HIGH  = 4;
    localparam int T_DONE  = 5;

    typedef struct packed {
        logic [7:0] hdr;
        logic [7:0] pay;
        logic [3:0] mode;
        logic [1:0] code;
    } vec_t;

    // mode: 0 normal, 1 init stuck high, 2 init stuck low, 3 no done, 4 no preamble
    localparam vec_t VECS [8] = '{
        '{8'd0,  8'd3, 4'd0, 2'd0},
        '{8'd7,  8'd5, 4'd0, 2'd0},
        '{8'd12, 8'd4, 4'd0, 2'd0},
        '{8'd1,  8'd0, 4'd0, 2'd0},
        '{8'd2,  8'd1, 4'd3, 2'd3},
        '{8'd6,  8'd0, 4'd4, 2'd3},
        '{8'd3,  8'd2, 4'd1, 2'd1},
        '{8'd3,  8'd2, 4'd2, 2'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_last = 1'b0;
    logic in_ready, prog_n, cfg_clk, cfg_dout, busy, done_ok, err;
    logic [1:0] err_code;
    logic init_n = 1'b1;
    logic done_in = 1'b0;

    int checks = 0;
    int fails = 0;
    int dev_mode = 0;
    int exp_bits = 0;
    int slen = 0;
    logic [7:0] strm [0:63];
    logic ebits [0:511];
    logic rx_bits [0:511];
    int rx_cnt = 0;

    always #2 clk = ~clk;

    fpga_serial_loader #(
        .CLK_DIV(CLK_DIV), .TICK_CYCLES(TICK), .INIT_LOW_TICKS(T_LOW),
        .INIT_HIGH_TICKS(T_HIGH), .DONE_TICKS(T_DONE)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .prog_n(prog_n), .cfg_clk(cfg_clk), .cfg_dout(cfg_dout),
        .init_n(init_n), .done_in(done_in), .busy(busy), .done_ok(done_ok),
        .err(err), .err_code(err_code)
    );

    // device model: init line
    int lo_wait = 0;
    int hi_wait = 0;
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            init_n = 1'b1; lo_wait = 0; hi_wait = 0;
        end else if (!prog_n) begin
            hi_wait = 0;
            if (dev_mode != 1) begin
                if (lo_wait >= 5) init_n = 1'b0; else lo_wait++;
            end
        end else begin
            lo_wait = 0;
            if (!init_n && dev_mode != 2) begin
                if (hi_wait >= 8) init_n = 1'b1; else hi_wait++;
            end
        end
    end

    // device model: done line
    always @(posedge clk) begin
        #1;
        if (!prog_n) done_in = 1'b0;
        else if (dev_mode != 3 && exp_bits != 0 && rx_cnt == exp_bits) done_in = 1'b1;
    end

    // device model: bit capture on rising configuration clock
    always @(posedge cfg_clk or negedge prog_n) begin
        if (!prog_n) rx_cnt <= 0;
        else if (rst_n && busy) begin
            if (rx_cnt < 512) rx_bits[rx_cnt] <= cfg_dout;
            rx_cnt <= rx_cnt + 1;
        end
    end

    // port monitors
    int cyc = 0;
    int t_fall = 0, t_rel = 0, t_err = 0;
    int v_rdy_shift = 0, v_rdy_init = 0, v_rel = 0, v_low = 0, v_data = 0, rdy_seen = 0;
    int low_run = 0;
    logic p_clk = 1'b1, p_dout = 1'b1, p_busy = 1'b0, p_prog = 1'b1, p_init = 1'b1, p_err = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!prog_n && p_prog) t_fall = cyc;
            if (prog_n && !p_prog) begin
                t_rel = cyc;
                if (!err && p_init) v_rel++;
            end
            if (err && !p_err) t_err = cyc;
            if (in_ready) rdy_seen++;
            if (in_ready && !cfg_clk) v_rdy_shift++;
            if (in_ready && !init_n) v_rdy_init++;
            if (!cfg_clk) low_run++;
            else begin
                if (!p_clk && low_run != CLK_DIV) v_low++;
                low_run = 0;
            end
            if (busy && p_busy && cfg_dout != p_dout && !(p_clk && !cfg_clk)) v_data++;
        end
        p_clk = cfg_clk; p_dout = cfg_dout; p_busy = busy;
        p_prog = prog_n; p_init = init_n; p_err = err;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic build(input int hdr, input int pay, input int mode);
        int first;
        slen = 0;
        for (int k = 0; k < hdr; k++) begin
            strm[slen] = ((k % 5) < 3) ? 8'hFF : 8'(8'h10 + k);
            slen++;
        end
        if (mode != 4) begin
            for (int k = 0; k < 4; k++) begin strm[slen] = 8'hFF; slen++; end
        end
        for (int p = 0; p < pay; p++) begin
            strm[slen] = 8'(p * 8'h5B + 8'h3C + hdr);
            slen++;
        end
        first = -1;
        for (int i = 0; i + 3 < slen; i++) begin
            if (first < 0 && strm[i] == 8'hFF && strm[i+1] == 8'hFF &&
                strm[i+2] == 8'hFF && strm[i+3] == 8'hFF) first = i;
        end
        exp_bits = 0;
        if (first >= 0) begin
            for (int i = first; i < slen; i++) begin
                for (int b = 7; b >= 0; b--) begin
                    ebits[exp_bits] = strm[i][b];
                    exp_bits++;
                end
            end
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic feed();
        bit stop;
        stop = 0;
        for (int b = 0; b < slen; b++) begin
            if (!stop) begin
                in_valid = 1'b1; in_data = strm[b]; in_last = (b == slen - 1);
                while (!in_ready && busy) @(negedge clk);
                if (!busy) stop = 1;
                else @(negedge clk);
            end
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while (busy && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic check_bits(input string req);
        int bad;
        bad = -1;
        for (int i = 0; i < exp_bits; i++) begin
            if (bad < 0 && rx_bits[i] !== ebits[i]) bad = i;
        end
        chk(rx_cnt == exp_bits, req, "shifted bit count", rx_cnt, exp_bits);
        chk(bad < 0, req, "first mismatching bit index", bad, -1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(prog_n && cfg_clk && cfg_dout, "R1", "pins idle high", {prog_n, cfg_clk, cfg_dout}, 7);
        chk(!busy && !done_ok && !err && err_code == 0, "R1", "status clear",
            {busy, done_ok, err, err_code}, 0);
        chk(!in_ready, "R1", "in_ready low", in_ready, 0);

        // vector table walk
        for (int v = 0; v < 8; v++) begin
            dev_mode = VECS[v].mode;
            build(VECS[v].hdr, VECS[v].pay, VECS[v].mode);
            repeat (20) @(negedge clk);
            pulse_start();
            feed();
            wait_idle();
            repeat (2) @(negedge clk);
            case (VECS[v].code)
                2'd0: begin
                    chk(done_ok && !err && err_code == 0, "R7", "success status",
                        {done_ok, err, err_code}, 4'b1000);
                    check_bits("R4/R5");
                end
                2'd1: begin
                    chk(err && err_code == 1, "R8", "init-low timeout code", err_code, 1);
                    chk(t_err - t_fall >= T_LOW * TICK - 2 && t_err - t_fall <= T_LOW * TICK + 2,
                        "R8", "init-low timeout delay", t_err - t_fall, T_LOW * TICK);
                end
                2'd2: begin
                    chk(err && err_code == 2, "R9", "init-high timeout code", err_code, 2);
                    chk(t_err - t_rel >= T_HIGH * TICK - 2 && t_err - t_rel <= T_HIGH * TICK + 2,
                        "R9", "init-high timeout delay", t_err - t_rel, T_HIGH * TICK);
                end
                default: begin
                    chk(err && err_code == 3 && !done_ok, "R10", "done/stream error code", err_code, 3);
                end
            endcase
            if (VECS[v].code != 0) begin
                chk(prog_n && cfg_clk && cfg_dout && !busy, "R11", "pins idle after error",
                    {prog_n, cfg_clk, cfg_dout, busy}, 14);
            end
        end

        // R2: start ignored while waiting for bytes
        dev_mode = 0;
        build(2, 2, 0);
        repeat (20) @(negedge clk);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(!prog_n && busy, "R2", "prog_n low and busy after start", {prog_n, busy}, 1);
        while (!in_ready) @(negedge clk);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(prog_n && in_ready, "R2", "start ignored while busy", {prog_n, in_ready}, 3);
        feed();
        wait_idle();
        @(negedge clk);
        chk(done_ok && !err, "R7", "success after ignored start", done_ok, 1);
        check_bits("R4");

        // R11: error held until next start, then cleared
        dev_mode = 1;
        build(0, 1, 0);
        repeat (20) @(negedge clk);
        pulse_start();
        wait_idle();
        repeat (30) @(negedge clk);
        chk(err && err_code == 1 && prog_n && cfg_clk && cfg_dout, "R11", "error held",
            {err, err_code, prog_n, cfg_clk, cfg_dout}, 6'b101111);
        dev_mode = 0;
        repeat (10) @(negedge clk);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(!err && err_code == 0 && busy, "R11", "start clears error", {err, err_code, busy}, 1);
        feed();
        wait_idle();
        @(negedge clk);
        chk(done_ok, "R7", "success after cleared error", done_ok, 1);

        // port monitor results
        chk(v_rel == 0, "R3", "prog_n released without init low", v_rel, 0);
        chk(v_rdy_init == 0, "R3", "in_ready while init low", v_rdy_init, 0);
        chk(v_rdy_shift == 0 && rdy_seen > 0, "R6", "in_ready during shifting", v_rdy_shift, 0);
        chk(v_low == 0, "R5", "clock low phase length errors", v_low, 0);
        chk(v_data == 0, "R5", "data changes off falling edge", v_data, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule